// File: doc/BRIEF.md
# Byte Repetition Run-Length Encoder

This block squeezes a byte stream that is dominated by long runs of one value, typically packed hit flags where 0xFF repeats for long stretches. It keeps one held byte and a repeat counter. A byte equal to the held one only advances the counter. When a different byte arrives, the block writes one symbol to a repetition stream. The symbol is the held byte alone when it was not repeated. Otherwise it is the held byte followed by its repeat count. The incoming byte then becomes the new held byte.

Each symbol also adds one bit to a separate header stream that records the form of the symbol: 0 for a lone byte, 1 for a byte with a count. The header bits are packed into bytes. A flush request writes out the pending held byte and then the partly filled header byte, so that a stream can be closed cleanly.

The input and both output streams use valid/ready handshakes.

Top module: `byte_rle_encoder`

## Requirements
- R1: After reset, `inReady` is 1 and both output valids are 0. The first byte accepted after reset or after a flush becomes the held byte and produces no output.
- R2: A byte equal to the held byte increments the repeat count and emits nothing, as long as the count is below 255.
- R3: A differing byte with a repeat count of 0 emits the held byte as a single repetition-stream byte and adds header bit 0. The incoming byte then becomes the held byte with count 0.
- R4: A differing byte with a nonzero count N emits two consecutive repetition-stream bytes, the held byte first and N second, and adds header bit 1. N is the number of copies minus one.
- R5: When the count has reached 255, a further equal byte emits the pair (byte, 255) with header bit 1 and starts a new run of the same byte with count 0. A run of 256 equal bytes therefore yields exactly one pair with count 255.
- R6: Header bits are packed least significant bit first. The first symbol of a header byte lands in bit 0. A header byte is sent as soon as 8 bits are collected, after the repetition bytes of the symbol that filled it.
- R7: While `flushReq` is 1, the pending held byte (with its count, if nonzero) is emitted. Then a partial header byte, padded with zeros in its upper bits, is sent if any bits are pending. After that `flushDone` is 1 and the block holds no byte. A flush with nothing pending emits nothing.
- R8: An output whose valid is 1 and whose ready is 0 keeps valid and data unchanged in the next cycle. `inReady` is 0 while a symbol or header byte is being sent and while `flushReq` is 1. The two output valids are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte is valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Block accepts an input byte |
| flushReq | input | 1 | Level request to close the stream |
| flushDone | output | 1 | Flush complete; block is empty |
| repValid | output | 1 | Repetition-stream byte is valid |
| repData | output | 8 | Repetition-stream byte (held byte or count) |
| repReady | input | 1 | Sink accepts a repetition-stream byte |
| hdrValid | output | 1 | Header byte is valid |
| hdrData | output | 8 | Packed header bits, LSB first |
| hdrReady | input | 1 | Sink accepts a header byte |

## Verification
The encoder is driven with several kinds of input:
- Runs of distinct single bytes, which exercise only lone-byte symbols and all-zero headers.
- A sweep of run-length pairs (0xFF runs of 1 to 9 bytes against 0x00 runs of 1 to 4), which tells a count of 0 apart from small nonzero counts and moves header bits across byte boundaries.
- Runs of 256, 257 and 513 equal bytes, which probe the counter's saturation point and the run that restarts after it.
- Symbol sequences that end exactly on a full header byte, and a flush with nothing pending, which separate padding of a partial header from sending no header at all.

The whole sweep is repeated with sinks that rarely accept, which exposes any loss or reordering under back-pressure.

// File: rtl/rle_pkg.sv
package rle_pkg;

  typedef enum logic [2:0] {
    ST_EMPTY,
    ST_RUN,
    ST_SEND_BYTE,
    ST_SEND_CNT,
    ST_SEND_HDR
  } rleState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHeld;   // take incoming byte as held, count cleared
    logic incCnt;     // one more repeat of the held byte
    logic capture;    // latch held byte and count as a symbol, push header bit
    logic clearHdr;   // header byte handed off
  } rleStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic match;      // incoming byte equals held byte
    logic cntFull;    // repeat count at its maximum
    logic outPair;    // captured symbol carries a count
    logic hdrFull;    // header byte complete
    logic hdrEmpty;   // no header bits pending
  } rleStatus_t;

endpackage

// File: rtl/rle_datapath.sv
module rle_datapath
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rleStrobe_t        strobe,
  input  logic              repSelCnt,
  input  logic [DATA_W-1:0] inData,
  output rleStatus_t        status,
  output logic [DATA_W-1:0] repData,
  output logic [HDR_W-1:0]  hdrData
);

  localparam int HC_W = $clog2(HDR_W + 1);
  localparam logic [DATA_W-1:0] CNT_MAX  = {DATA_W{1'b1}};
  localparam logic [HC_W-1:0]   HDR_FULL = HC_W'(HDR_W);

  logic [DATA_W-1:0] heldByte;
  logic [DATA_W-1:0] repCnt;
  logic [DATA_W-1:0] symByte;
  logic [DATA_W-1:0] symCnt;
  logic              symPair;
  logic [HDR_W-1:0]  hdrAcc;
  logic [HC_W-1:0]   hdrCnt;
  logic              pairBit;

  assign pairBit = (repCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldByte <= '0;
      repCnt   <= '0;
    end else if (strobe.loadHeld) begin
      heldByte <= inData;
      repCnt   <= '0;
    end else if (strobe.incCnt) begin
      repCnt   <= repCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symByte <= '0;
      symCnt  <= '0;
      symPair <= 1'b0;
    end else if (strobe.capture) begin
      symByte <= heldByte;
      symCnt  <= repCnt;
      symPair <= pairBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrAcc <= '0;
      hdrCnt <= '0;
    end else if (strobe.clearHdr) begin
      hdrAcc <= '0;
      hdrCnt <= '0;
    end else if (strobe.capture) begin
      hdrAcc <= hdrAcc | (HDR_W'(pairBit) << hdrCnt);
      hdrCnt <= hdrCnt + 1'b1;
    end
  end

  always_comb begin
    status.match    = (inData == heldByte);
    status.cntFull  = (repCnt == CNT_MAX);
    status.outPair  = symPair;
    status.hdrFull  = (hdrCnt == HDR_FULL);
    status.hdrEmpty = (hdrCnt == '0);
  end

  assign repData = repSelCnt ? symCnt : symByte;
  assign hdrData = hdrAcc;

  // R5: control never advances a saturated counter
  a_r5_no_cnt_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incCnt |-> (repCnt != CNT_MAX));

  // R6: a full header byte is always drained before another symbol is captured
  a_r6_hdr_room: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (hdrCnt != HDR_FULL));

endmodule

// File: rtl/rle_ctrl.sv
module rle_ctrl
  import rle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       flushReq,
  input  logic       repReady,
  input  logic       hdrReady,
  input  rleStatus_t status,
  output rleStrobe_t strobe,
  output logic       repSelCnt,
  output logic       inReady,
  output logic       flushDone,
  output logic       repValid,
  output logic       hdrValid
);

  rleState_t state, stateNext;
  logic      flushing, flushingNext;
  rleState_t afterRep;
  logic      afterRepClear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_EMPTY;
      flushing <= 1'b0;
    end else begin
      state    <= stateNext;
      flushing <= flushingNext;
    end
  end

  // where to go once the repetition bytes of a symbol are out
  always_comb begin
    afterRepClear = 1'b0;
    if (status.hdrFull || (flushing && !status.hdrEmpty)) begin
      afterRep = ST_SEND_HDR;
    end else if (flushing) begin
      afterRep      = ST_EMPTY;
      afterRepClear = 1'b1;
    end else begin
      afterRep = ST_RUN;
    end
  end

  always_comb begin
    stateNext    = state;
    flushingNext = flushing;
    strobe       = '0;
    repSelCnt    = 1'b0;
    inReady      = 1'b0;
    flushDone    = 1'b0;
    repValid     = 1'b0;
    hdrValid     = 1'b0;
    unique case (state)
      ST_EMPTY: begin
        if (flushReq) begin
          flushDone = 1'b1;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            strobe.loadHeld = 1'b1;
            stateNext       = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (flushReq) begin
          strobe.capture = 1'b1;
          flushingNext   = 1'b1;
          stateNext      = ST_SEND_BYTE;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            if (status.match && !status.cntFull) begin
              strobe.incCnt = 1'b1;
            end else begin
              strobe.capture  = 1'b1;
              strobe.loadHeld = 1'b1;
              stateNext       = ST_SEND_BYTE;
            end
          end
        end
      end
      ST_SEND_BYTE: begin
        repValid = 1'b1;
        if (repReady) begin
          if (status.outPair) begin
            stateNext = ST_SEND_CNT;
          end else begin
            stateNext = afterRep;
            if (afterRepClear) flushingNext = 1'b0;
          end
        end
      end
      ST_SEND_CNT: begin
        repValid  = 1'b1;
        repSelCnt = 1'b1;
        if (repReady) begin
          stateNext = afterRep;
          if (afterRepClear) flushingNext = 1'b0;
        end
      end
      ST_SEND_HDR: begin
        hdrValid = 1'b1;
        if (hdrReady) begin
          strobe.clearHdr = 1'b1;
          if (flushing) begin
            stateNext    = ST_EMPTY;
            flushingNext = 1'b0;
          end else begin
            stateNext = ST_RUN;
          end
        end
      end
      default: stateNext = ST_EMPTY;
    endcase
  end

  // R8: no new input is taken while a symbol is on its way out
  a_r8_no_input_while_emit: assert property (@(posedge clk) disable iff (!rstN)
    (repValid || hdrValid) |-> !inReady);

  // R4: the count byte always directly follows the byte it belongs to
  a_r4_count_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    (repValid && repSelCnt) |-> $past(repValid));

endmodule

// File: rtl/byte_rle_encoder.sv
module byte_rle_encoder
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HDR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  input  logic              flushReq,
  output logic              flushDone,
  output logic              repValid,
  output logic [DATA_W-1:0] repData,
  input  logic              repReady,
  output logic              hdrValid,
  output logic [HDR_W-1:0]  hdrData,
  input  logic              hdrReady
);

  rleStrobe_t strobe;
  rleStatus_t status;
  logic       repSelCnt;

  rle_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .flushReq  (flushReq),
    .repReady  (repReady),
    .hdrReady  (hdrReady),
    .status    (status),
    .strobe    (strobe),
    .repSelCnt (repSelCnt),
    .inReady   (inReady),
    .flushDone (flushDone),
    .repValid  (repValid),
    .hdrValid  (hdrValid)
  );

  rle_datapath #(
    .DATA_W (DATA_W),
    .HDR_W  (HDR_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .repSelCnt (repSelCnt),
    .inData    (inData),
    .status    (status),
    .repData   (repData),
    .hdrData   (hdrData)
  );

  // R8: stalled outputs hold valid and data
  a_r8_rep_hold: assert property (@(posedge clk) disable iff (!rstN)
    (repValid && !repReady) |=> (repValid && $stable(repData)));

  a_r8_hdr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !hdrReady) |=> (hdrValid && $stable(hdrData)));

  // R8: one output stream at a time
  a_r8_one_stream: assert property (@(posedge clk) disable iff (!rstN)
    !(repValid && hdrValid));

  // R7: a finished flush leaves nothing on the outputs
  a_r7_flush_clean: assert property (@(posedge clk) disable iff (!rstN)
    flushDone |-> (!repValid && !hdrValid && !inReady));

endmodule

// File: tb/byte_rle_encoder_bench.sv
module byte_rle_encoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inReady;
  logic       flushReq = 1'b0;
  logic       flushDone;
  logic       repValid;
  logic [7:0] repData;
  logic       repReady = 1'b0;
  logic       hdrValid;
  logic [7:0] hdrData;
  logic       hdrReady = 1'b0;

  byte_rle_encoder u_byte_rle_encoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .flushReq(flushReq), .flushDone(flushDone),
    .repValid(repValid), .repData(repData), .repReady(repReady),
    .hdrValid(hdrValid), .hdrData(hdrData), .hdrReady(hdrReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int totalChecks = 0;
  int failChecks  = 0;
  int cycles      = 0;
  int readyMode   = 0;   // 0: always ready, 1: half the time, 2: a quarter of the time

  logic [7:0] gotRep[$];
  logic [7:0] gotHdr[$];
  logic [7:0] expRep[$];
  logic [7:0] expHdr[$];

  // reference state, built from the requirements
  logic [7:0] refHeld;
  int         refCnt;
  bit         refHas = 0;
  logic [7:0] refHdrAcc = '0;
  int         refHdrCnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      failChecks++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit pick();
    case (readyMode)
      0:       return 1'b1;
      1:       return ($urandom % 2) == 0;
      default: return ($urandom % 4) == 0;
    endcase
  endfunction

  // output monitor: ready changes at the falling edge, transfers counted for the next rising edge
  initial forever begin
    @(negedge clk);
    repReady = pick();
    hdrReady = pick();
    #1;
    if (rstN && repValid && repReady) gotRep.push_back(repData);
    if (rstN && hdrValid && hdrReady) gotHdr.push_back(hdrData);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      totalChecks++;
      failChecks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end

  task automatic refHdrBit(input bit b);
    refHdrAcc[refHdrCnt] = b;
    refHdrCnt++;
    if (refHdrCnt == 8) begin
      expHdr.push_back(refHdrAcc);
      refHdrAcc = '0;
      refHdrCnt = 0;
    end
  endtask

  task automatic refEmit();
    expRep.push_back(refHeld);
    if (refCnt != 0) begin
      expRep.push_back(8'(refCnt));
      refHdrBit(1'b1);
    end else begin
      refHdrBit(1'b0);
    end
  endtask

  task automatic refFeed(input logic [7:0] b);
    if (!refHas) begin
      refHas = 1; refHeld = b; refCnt = 0;
    end else if (b == refHeld && refCnt != 255) begin
      refCnt++;
    end else begin
      refEmit();
      refHeld = b; refCnt = 0;
    end
  endtask

  task automatic refFlush();
    if (refHas) refEmit();
    refHas = 0;
    if (refHdrCnt != 0) begin
      expHdr.push_back(refHdrAcc);
      refHdrAcc = '0;
      refHdrCnt = 0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    #2;
    while (!inReady) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
    refFeed(b);
  endtask

  task automatic sendRun(input logic [7:0] b, input int len);
    for (int i = 0; i < len; i++) sendByte(b);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doFlush(input string tag);
    @(negedge clk);
    flushReq = 1'b1;
    #2;
    while (!flushDone) begin
      @(negedge clk);
      #2;
    end
    check(inReady == 1'b0, {tag, " inReady low during flush"}, inReady, 0);
    @(negedge clk);
    flushReq = 1'b0;
    refFlush();
    check(gotRep.size() == expRep.size(), {tag, " rep length"}, gotRep.size(), expRep.size());
    for (int i = 0; i < expRep.size() && i < gotRep.size(); i++)
      check(gotRep[i] == expRep[i], {tag, " rep byte"}, gotRep[i], expRep[i]);
    check(gotHdr.size() == expHdr.size(), {tag, " hdr length"}, gotHdr.size(), expHdr.size());
    for (int i = 0; i < expHdr.size() && i < gotHdr.size(); i++)
      check(gotHdr[i] == expHdr[i], {tag, " hdr byte"}, gotHdr[i], expHdr[i]);
    gotRep.delete(); gotHdr.delete(); expRep.delete(); expHdr.delete();
  endtask

  task automatic sweep(input string tag);
    for (int a = 1; a <= 9; a++) begin
      for (int z = 1; z <= 4; z++) begin
        sendRun(8'hFF, a);
        sendRun(8'h00, z);
        sendRun(8'hFF, 1);
        sendRun(8'h3C, z);
        doFlush(tag);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(inReady == 1'b1, "R1 reset inReady", inReady, 1);
    check(repValid == 1'b0, "R1 reset repValid", repValid, 0);
    check(hdrValid == 1'b0, "R1 reset hdrValid", hdrValid, 0);
    rstN = 1'b1;

    // R7: flush with nothing pending
    doFlush("R7 empty flush");

    // R1: first byte is silent
    sendByte(8'h5A);
    idle(10);
    check(gotRep.size() == 0, "R1 first byte silent", gotRep.size(), 0);
    // R2: repeats are silent
    sendRun(8'h5A, 4);
    idle(10);
    check(gotRep.size() == 0 && gotHdr.size() == 0, "R2 repeats silent", gotRep.size(), 0);
    doFlush("R4 R7 pending pair");

    // R3: distinct single bytes, 9 symbols cross a header byte boundary
    for (int i = 1; i <= 9; i++) sendByte(8'(i * 17));
    doFlush("R3 R6 singles");

    // R6: exactly 8 symbols leaves no partial header
    for (int i = 0; i < 4; i++) begin
      sendRun(8'hFF, 2);
      sendByte(8'h00);
    end
    doFlush("R6 full header byte");

    // R4: run-length sweep with free-running sinks
    sweep("R4 sweep");

    // R5: saturation
    sendRun(8'hAA, 256);
    sendByte(8'h11);
    doFlush("R5 run 256");
    sendRun(8'hAA, 257);
    doFlush("R5 run 257");
    sendRun(8'hFF, 513);
    sendByte(8'hFE);
    doFlush("R5 run 513");

    // R8: back-pressure
    readyMode = 1;
    sweep("R8 half ready");
    readyMode = 2;
    sweep("R8 quarter ready");
    sendRun(8'hFF, 300);
    doFlush("R8 R5 stalled saturation");

    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

endmodule